// File: doc/BRIEF.md
# MDIO Management Master

This block is a register-mapped peripheral that runs one Clause-22 MDIO management transaction at a time on behalf of software. Software places a 16-bit payload in a write-data register and then writes one control word. That word names a PHY address, a register number and the direction of the access. The block then builds a complete serial frame, clocks it out on MDC and MDIO, and for reads collects the 16 bits the PHY returns.

The register bus is a simple strobe interface with a word address. Writes take effect on the clock edge where the write strobe is high. Read data comes out of a register and is valid on the cycle after the read strobe. MDC comes from the system clock through a divider whose half period is a parameter. MDIO is presented as three signals, output, output enable and input, so that a pad buffer outside the block can form the tri-state line. A busy bit in the control register stays set for the whole frame. While it is set, further commands are refused.

Top module: `mdio_master`

## Requirements
- R1: After reset the control and read-data registers read 0, MDC is low and `mdio_oe` is low.
- R2: A control write (offset 0x0) with bit 12 set and exactly one of bit 10 (write) or bit 11 (read) set launches a frame. Bit 12 of the control register then reads 1 until the frame ends, 128*DIV_HALF clock cycles after the launching edge.
- R3: The control register reads bit 12 = busy, bit 11 = read, bit 10 = write, bits 9:5 = PHY address and bits 4:0 = register number, all taken from the last accepted command. Every other bit reads 0.
- R4: A write frame is, MSB first and one bit per MDC period: 32 ones, start 01, opcode 01, five PHY address bits, five register bits, turnaround 10, then the low 16 bits of the write-data register (offset 0x8). `mdio_oe` stays high for all 64 bits.
- R5: A read frame uses opcode 10. `mdio_oe` is high for the first 46 bits and low for the two turnaround bits and the 16 data bits.
- R6: On a read, the 16 data bits are sampled on rising MDC edges, MSB first. They appear in bits 15:0 of the read-data register (offset 0x4), with bits 31:16 reading 0.
- R7: During a frame, each MDC high phase and each MDC low phase lasts DIV_HALF clock cycles. MDC is low while the block is idle. MDIO output and enable change only where MDC falls.
- R8: A control write made while busy has no effect: the running frame, the command fields and the busy timing are unchanged, and no second frame follows.
- R9: A control write with bit 12 clear, or with bits 11:10 equal to 00 or 11, launches nothing and leaves the control register unchanged.
- R10: The write-data register reads back its low 16 bits, with bits 31:16 reading 0. Unmapped offsets read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | ADDR_W | Byte offset of the register |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Register read data, valid the cycle after `reg_rd` |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | MDIO value driven by the block |
| mdio_oe | output | 1 | MDIO drive enable |
| mdio_i | input | 1 | MDIO value seen at the pad |

## Verification
The busy bit rises on the launching edge and falls exactly 128*DIV_HALF edges later. The bench therefore times its two control reads so that one is sampled on that last edge and must still see busy, and the next is sampled one edge later and must see it clear. Register reads are checked on the falling clock edge one cycle after the strobe. A PHY model follows MDC itself: it records MDIO on each rising MDC and drives read data after each falling MDC. This lets frame content, turnaround release and returned data be checked without reference to absolute cycles. MDC half periods are measured in simulation time against DIV_HALF clock periods.

// File: rtl/mdio_pkg.sv
package mdio_pkg;

  localparam int PRE_BITS   = 32;
  localparam int FRAME_BITS = PRE_BITS + 32;
  localparam int TA_POS     = PRE_BITS + 14;
  localparam int DATA_POS   = PRE_BITS + 16;
  localparam int PAY_W      = 16;

  localparam int OFS_CTRL  = 0;
  localparam int OFS_RDATA = 4;
  localparam int OFS_WDATA = 8;

  localparam int BIT_GO = 12;
  localparam int BIT_RD = 11;
  localparam int BIT_WR = 10;

  typedef struct packed {
    logic       rd;
    logic       wr;
    logic [4:0] phy;
    logic [4:0] regn;
  } cmd_t;

endpackage

// File: rtl/mdio_clkgen.sv
module mdio_clkgen #(
  parameter int HALF = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic run,
  output logic mdc,
  output logic rise,
  output logic fall
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  logic [CW-1:0] cnt;
  logic          tick;

  assign tick = run && (cnt == CW'(HALF - 1));
  assign rise = tick && !mdc;
  assign fall = tick && mdc;

  always_ff @(posedge clk) begin
    if (rst || !run) begin
      cnt <= '0;
      mdc <= 1'b0;
    end else if (tick) begin
      cnt <= '0;
      mdc <= ~mdc;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end
endmodule

// File: rtl/mdio_frame.sv
module mdio_frame
  import mdio_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic             op_rd,
  input  logic [4:0]       phy,
  input  logic [4:0]       regn,
  input  logic [PAY_W-1:0] payload,
  input  logic             rise,
  input  logic             fall,
  input  logic             mdio_i,
  output logic             busy,
  output logic             mdio_o,
  output logic             mdio_oe,
  output logic [PAY_W-1:0] rd_word
);
  localparam int IDX_W = $clog2(FRAME_BITS);

  logic [FRAME_BITS-1:0] shreg;
  logic [IDX_W-1:0]      idx;
  logic [IDX_W-1:0]      idx_nxt;
  logic                  is_rd;
  logic [PAY_W-1:0]      rd_sh;

  assign idx_nxt = idx + IDX_W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      shreg   <= '0;
      idx     <= '0;
      is_rd   <= 1'b0;
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b0;
      rd_sh   <= '0;
      rd_word <= '0;
    end else if (start && !busy) begin
      busy    <= 1'b1;
      is_rd   <= op_rd;
      idx     <= '0;
      shreg   <= {{PRE_BITS{1'b1}}, 2'b01, (op_rd ? 2'b10 : 2'b01), phy, regn,
                  (op_rd ? 2'b11 : 2'b10), (op_rd ? {PAY_W{1'b1}} : payload)};
      mdio_o  <= 1'b1;
      mdio_oe <= 1'b1;
    end else if (busy) begin
      if (rise && is_rd && (idx >= IDX_W'(DATA_POS)))
        rd_sh <= {rd_sh[PAY_W-2:0], mdio_i};
      if (fall) begin
        if (idx == IDX_W'(FRAME_BITS - 1)) begin
          busy    <= 1'b0;
          mdio_o  <= 1'b1;
          mdio_oe <= 1'b0;
          if (is_rd)
            rd_word <= rd_sh;
        end else begin
          idx     <= idx_nxt;
          shreg   <= {shreg[FRAME_BITS-2:0], 1'b1};
          mdio_o  <= shreg[FRAME_BITS-2];
          mdio_oe <= !(is_rd && (idx_nxt >= IDX_W'(TA_POS)));
        end
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int DIV_HALF = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic              reg_rd,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              mdc,
  output logic              mdio_o,
  output logic              mdio_oe,
  input  logic              mdio_i
);
  logic             busy;
  logic             go;
  logic             rise;
  logic             fall;
  cmd_t             cmd_q;
  logic [PAY_W-1:0] wdata_q;
  logic [PAY_W-1:0] rd_word;
  logic [DATA_W-1:0] rd_mux;

  assign go = reg_wr && (reg_addr == ADDR_W'(OFS_CTRL)) && reg_wdata[BIT_GO]
              && (reg_wdata[BIT_RD] ^ reg_wdata[BIT_WR]) && !busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= '0;
      wdata_q <= '0;
    end else begin
      if (go)
        cmd_q <= cmd_t'(reg_wdata[BIT_RD:0]);
      if (reg_wr && (reg_addr == ADDR_W'(OFS_WDATA)))
        wdata_q <= reg_wdata[PAY_W-1:0];
    end
  end

  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(OFS_CTRL))
      rd_mux[BIT_GO:0] = {busy, cmd_q};
    else if (reg_addr == ADDR_W'(OFS_RDATA))
      rd_mux[PAY_W-1:0] = rd_word;
    else if (reg_addr == ADDR_W'(OFS_WDATA))
      rd_mux[PAY_W-1:0] = wdata_q;
  end

  always_ff @(posedge clk) begin
    if (rst)
      reg_rdata <= '0;
    else if (reg_rd)
      reg_rdata <= rd_mux;
  end

  mdio_clkgen #(.HALF(DIV_HALF)) u_clkgen (
    .clk  (clk),
    .rst  (rst),
    .run  (busy),
    .mdc  (mdc),
    .rise (rise),
    .fall (fall)
  );

  mdio_frame u_frame (
    .clk     (clk),
    .rst     (rst),
    .start   (go),
    .op_rd   (reg_wdata[BIT_RD]),
    .phy     (reg_wdata[9:5]),
    .regn    (reg_wdata[4:0]),
    .payload (wdata_q),
    .rise    (rise),
    .fall    (fall),
    .mdio_i  (mdio_i),
    .busy    (busy),
    .mdio_o  (mdio_o),
    .mdio_oe (mdio_oe),
    .rd_word (rd_word)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk #(
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_wr,
  input logic [ADDR_W-1:0] reg_addr,
  input logic              go_bit,
  input logic              busy,
  input logic [11:0]       cmd_q,
  input logic              mdc,
  input logic              mdio_o,
  input logic              mdio_oe
);
  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && reg_wr && reg_addr == '0) |=> $stable(cmd_q));

  // R2
  launch_src_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(reg_wr && reg_addr == '0 && go_bit));

  // R7
  mdio_edge_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && !$fell(mdc)) |-> ($stable(mdio_o) && $stable(mdio_oe)));

  // R7
  mdc_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mdc);

  // R5
  oe_release_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $fell(mdio_oe)) |-> cmd_q[11]);
endmodule

bind mdio_master mdio_master_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_wr   (reg_wr),
  .reg_addr (reg_addr),
  .go_bit   (reg_wdata[12]),
  .busy     (busy),
  .cmd_q    (cmd_q),
  .mdc      (mdc),
  .mdio_o   (mdio_o),
  .mdio_oe  (mdio_oe)
);

// File: tb/mdio_master_bench.sv
`timescale 1ns/1ps
module mdio_master_bench;
  localparam int H = 4;
  localparam int FRAME_CYC = 128 * H;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe, mdio_i;

  int nchk = 0;
  int nfail = 0;
  bit done = 0;

  // PHY model state
  logic [63:0] cap_o = '0;
  logic [63:0] cap_oe = '0;
  int          rc = 0;
  logic [15:0] phy_val = '0;
  logic        phy_drv = 1'b1;
  bit          first = 1;
  int          bad = 0;
  longint      last_t = 0;

  always #5 clk = ~clk;

  mdio_master #(.ADDR_W(4), .DATA_W(32), .DIV_HALF(H)) u_mdio_master (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  assign mdio_i = mdio_oe ? mdio_o : phy_drv;

  always @(posedge mdc) begin
    cap_o  = {cap_o[62:0], mdio_o};
    cap_oe = {cap_oe[62:0], mdio_oe};
    rc     = rc + 1;
  end

  always @(negedge mdc) begin
    if (rc >= 48 && rc <= 63) phy_drv = phy_val[63 - rc];
    else phy_drv = 1'b1;
  end

  always @(mdc) begin
    if (!first && (longint'($time) - last_t != longint'(H * 10))) bad = bad + 1;
    first  = 0;
    last_t = longint'($time);
  end

  // {is_rd, phy, reg, data}
  localparam logic [26:0] VECS [7] = '{
    {1'b0, 5'h00, 5'h1d, 16'hffff},
    {1'b0, 5'h1f, 5'h00, 16'h0000},
    {1'b0, 5'h0a, 5'h15, 16'ha5c3},
    {1'b1, 5'h03, 5'h19, 16'h8001},
    {1'b1, 5'h1f, 5'h1f, 16'hffff},
    {1'b1, 5'h00, 5'h00, 16'h1234},
    {1'b0, 5'h11, 5'h0e, 16'h5a5a}
  };

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [3:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(posedge clk);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [3:0] a, output logic [31:0] d);
    reg_rd = 1'b1; reg_addr = a;
    @(posedge clk);
    @(negedge clk);
    reg_rd = 1'b0;
    d = reg_rdata;
  endtask

  task automatic arm_phy(input logic [15:0] v);
    phy_val = v; rc = 0; first = 1; bad = 0;
  endtask

  function automatic logic [63:0] wr_frame(input logic [4:0] p, input logic [4:0] r,
                                           input logic [15:0] d);
    return {32'hffff_ffff, 2'b01, 2'b01, p, r, 2'b10, d};
  endfunction

  task automatic run_vec(input logic [26:0] v);
    logic        is_rd;
    logic [4:0]  p, r;
    logic [15:0] dat;
    logic [31:0] d;
    is_rd = v[26]; p = v[25:21]; r = v[20:16]; dat = v[15:0];
    if (!is_rd) bus_write(4'h8, {16'habcd, dat});
    arm_phy(is_rd ? dat : 16'h0);
    bus_write(4'h0, {19'b0, 1'b1, is_rd, !is_rd, p, r});
    repeat (FRAME_CYC - 1) @(negedge clk);
    bus_read(4'h0, d);
    chk("R2 busy on last frame edge", 64'(d[12]), 64'd1);
    chk("R3 control readback", 64'(d), 64'({19'b0, 1'b1, is_rd, !is_rd, p, r}));
    bus_read(4'h0, d);
    chk("R2 busy clear after frame", 64'(d[12]), 64'd0);
    chk("R7 half periods", 64'(bad), 64'd0);
    chk("R4 bit count", 64'(rc), 64'd64);
    chk("R7 mdc idle low", 64'(mdc), 64'd0);
    if (!is_rd) begin
      chk("R4 write frame", cap_o, wr_frame(p, r, dat));
      chk("R4 oe during write", cap_oe, {64{1'b1}});
    end else begin
      chk("R5 read header", 64'(cap_o[63:18]), 64'({32'hffff_ffff, 2'b01, 2'b10, p, r}));
      chk("R5 read oe", cap_oe, {{46{1'b1}}, 18'b0});
      bus_read(4'h4, d);
      chk("R6 read data", 64'(d), 64'({16'h0, dat}));
    end
  endtask

  initial begin
    #(150000 * 10);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    chk("R1 mdc", 64'(mdc), 64'd0);
    chk("R1 oe", 64'(mdio_oe), 64'd0);
    bus_read(4'h0, d);
    chk("R1 control", 64'(d), 64'd0);
    bus_read(4'h4, d);
    chk("R1 read data", 64'(d), 64'd0);

    for (int i = 0; i < 7; i++) run_vec(VECS[i]);

    // R8 control write while busy
    bus_write(4'h8, 32'h0000_0f0f);
    arm_phy(16'h0);
    bus_write(4'h0, 32'h0000_1400 | {22'b0, 5'h05, 5'h06});
    repeat (20) @(negedge clk);
    bus_write(4'h0, 32'h0000_1800 | {22'b0, 5'h1f, 5'h1f});
    repeat (FRAME_CYC - 22) @(negedge clk);
    bus_read(4'h0, d);
    chk("R8 busy timing kept", 64'(d[12]), 64'd1);
    repeat (10) @(negedge clk);
    bus_read(4'h0, d);
    chk("R8 fields kept", 64'(d), 64'({22'b0, 2'b01, 5'h05, 5'h06}));
    chk("R8 frame kept", cap_o, wr_frame(5'h05, 5'h06, 16'h0f0f));
    repeat (100) @(negedge clk);
    chk("R8 no second frame", 64'(rc), 64'd64);

    // R9 invalid launches
    bus_write(4'h0, 32'h0000_1c00 | {22'b0, 5'h12, 5'h09});
    bus_read(4'h0, d);
    chk("R9 both op bits", 64'(d), 64'({22'b0, 2'b01, 5'h05, 5'h06}));
    bus_write(4'h0, 32'h0000_0800 | {22'b0, 5'h12, 5'h09});
    bus_read(4'h0, d);
    chk("R9 no start bit", 64'(d), 64'({22'b0, 2'b01, 5'h05, 5'h06}));
    bus_write(4'h0, 32'h0000_1000);
    bus_read(4'h0, d);
    chk("R9 no op bits", 64'(d), 64'({22'b0, 2'b01, 5'h05, 5'h06}));
    repeat (20) @(negedge clk);
    chk("R9 no frame", 64'(rc), 64'd64);

    // R10 write-data readback and unmapped offset
    bus_write(4'h8, 32'hdead_beef);
    bus_read(4'h8, d);
    chk("R10 wdata readback", 64'(d), 64'h0000_beef);
    bus_read(4'hc, d);
    chk("R10 unmapped", 64'(d), 64'd0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule